// File: doc/BRIEF.md
# Target Access Firewall

This block sits directly in front of one bus target and decides, within the same cycle, whether each incoming request may reach it. A set of address windows, each with its own base and size, is checked against the request. Each window carries three permission masks: which initiators may use it, which security domains may use it, and which of the four access kinds (user read, user write, supervisor read, supervisor write) are allowed. A request passes when at least one enabled window covers its address and allows its initiator, domain and access kind. Any other request is held back from the target and answered with an error pulse. Its details are recorded in an error log, and a sticky interrupt is raised.

Software programs the windows through a small word-addressed configuration port during boot and then sets a one-way lock. The configuration port has its own guard: only one designated initiator and domain pair, fixed by parameter, can change anything. Any window can instead be fixed at build time by parameter. Such a window then holds its values from reset onward and ignores writes.

Configuration word map (N windows): word 4r+0 base, 4r+1 size, 4r+2 permissions of window r; word 4N control (bit 0 lock); 4N+1 status (bit 0 interrupt, bit 1 overflow); 4N+2 logged address; 4N+3 logged attributes (bits 7:0 initiator, 15:8 domain, 17:16 access kind as {privileged, write}). Permission word: bit 0 enable, bits 7:4 access-kind mask indexed by {privileged, write} (bit 4 user read, 5 user write, 6 supervisor read, 7 supervisor write), bits 15:8 initiator mask indexed by initiator ID, bits 23:16 domain mask indexed by domain.

Top module: `tgt_guard`

## Requirements
- R1: After reset every software window reads back zero and is disabled, the lock and status read zero, and any request outside a hardwired window is denied.
- R2: A window covers an address when base <= address < base + size; the address equal to base + size and the address base - 1 are not covered by that window.
- R3: A request is allowed by a window only if the bit of the initiator mask selected by the request's initiator ID is set.
- R4: A request is allowed by a window only if the bit of the domain mask selected by the request's domain is set.
- R5: A request is allowed by a window only if the access-kind mask bit selected by {privileged, write} is set.
- R6: In every cycle with a valid request, exactly one of the forward strobe and the error pulse is high, in that same cycle; the forwarded address equals the request address. With no valid request, both are low.
- R7: When several windows cover an address, the request is allowed if any one of them allows it.
- R8: Writing 1 to control bit 0 sets the lock, which stays set until reset; while it is set, writes to window words have no effect.
- R9: A configuration write from any initiator and domain pair other than the designated one has no effect.
- R10: A hardwired window reads back its fixed values, ignores writes, and grants by them from reset.
- R11: On a denial with the log empty, the address, initiator, domain and access kind are captured and status bit 0 is set from the next cycle, staying set until cleared.
- R12: A denial while status bit 0 is set sets status bit 1 and leaves the first captured record unchanged.
- R13: An accepted write with data bit 0 set to the status word clears status bits 0 and 1 and empties the log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_priv | input | 1 | 1 for supervisor, 0 for user |
| req_init | input | IW | Initiator ID |
| req_dom | input | DW | Security domain |
| tgt_valid | output | 1 | Request forwarded to the target |
| tgt_addr | output | AW | Forwarded address |
| tgt_write | output | 1 | Forwarded write flag |
| tgt_priv | output | 1 | Forwarded privilege flag |
| req_err | output | 1 | Error response for a denied request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CAW | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_init | input | IW | Initiator ID of the configuration access |
| cfg_dom | input | DW | Domain of the configuration access |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| irq | output | 1 | Sticky violation interrupt |

## Verification
The assertions assume that a request is a single-cycle pulse that the bus does not retry on its own, and that the configuration port issues one write per cycle. Logging and overflow properties treat every error pulse as a fresh violation. The stimulus holds each request valid for exactly one cycle and spaces configuration writes and reads apart from requests. Clears are issued only with no request in the same cycle, so the properties never have to resolve a clear coinciding with a violation.

// File: rtl/tgt_guard_pkg.sv
package tgt_guard_pkg;

    // Word offsets inside one window's group of four configuration words
    localparam logic [1:0] OFS_BASE = 2'd0;
    localparam logic [1:0] OFS_SIZE = 2'd1;
    localparam logic [1:0] OFS_PERM = 2'd2;

    // Permission word field positions (decoded by the match logic)
    localparam int unsigned PERM_EN      = 0;
    localparam int unsigned PERM_KIND_LO = 4;
    localparam int unsigned PERM_INIT_LO = 8;
    localparam int unsigned PERM_DOM_LO  = 16;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] size;
        logic [31:0] perm;
    } window_t;

    typedef enum logic [1:0] {
        KIND_USER_RD = 2'b00,
        KIND_USER_WR = 2'b01,
        KIND_SUP_RD  = 2'b10,
        KIND_SUP_WR  = 2'b11
    } kind_e;

    function automatic kind_e kind_of(input logic priv, input logic write);
        return kind_e'({priv, write});
    endfunction

    // True when base <= addr < base + size, without wrap-around
    function automatic logic in_window(input logic [31:0] addr,
                                       input logic [31:0] base,
                                       input logic [31:0] size);
        logic [32:0] top;
        top = {1'b0, base} + {1'b0, size};
        return ({1'b0, addr} >= {1'b0, base}) && ({1'b0, addr} < top);
    endfunction

endpackage

// File: rtl/tgt_guard_regs.sv
module tgt_guard_regs
    import tgt_guard_pkg::*;
#(
    parameter int unsigned NR = 4,
    parameter int unsigned IW = 3,
    parameter int unsigned DW = 2,
    parameter int unsigned CAW = 5,
    parameter logic [IW-1:0] CFG_INIT = '1,
    parameter logic [DW-1:0] CFG_DOM = '1,
    parameter logic [NR-1:0] HARD_MASK = '0,
    parameter logic [NR*32-1:0] HARD_BASE = '0,
    parameter logic [NR*32-1:0] HARD_SIZE = '0,
    parameter logic [NR*32-1:0] HARD_PERM = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CAW-1:0]       cfg_addr,
    input  logic [31:0]          cfg_wdata,
    input  logic [IW-1:0]        cfg_init,
    input  logic [DW-1:0]        cfg_dom,
    output window_t [NR-1:0]     windows,
    output logic                 locked,
    output logic                 wr_ok
);
    localparam logic [CAW-1:0] CTRL_A = CAW'(NR * 4);

    // Second-layer guard on the configuration port
    assign wr_ok = cfg_we && (cfg_init == CFG_INIT) && (cfg_dom == CFG_DOM);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
        end else if (wr_ok && (cfg_addr == CTRL_A) && cfg_wdata[0]) begin
            locked <= 1'b1;
        end
    end

    for (genvar r = 0; r < NR; r++) begin : g_win
        if (HARD_MASK[r]) begin : g_fixed
            assign windows[r] = '{base: HARD_BASE[r*32 +: 32],
                                  size: HARD_SIZE[r*32 +: 32],
                                  perm: HARD_PERM[r*32 +: 32]};
        end else begin : g_soft
            window_t q;
            logic    hit;
            assign hit = wr_ok && !locked && (cfg_addr[CAW-1:2] == (CAW-2)'(r));
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (hit) begin
                    case (cfg_addr[1:0])
                        OFS_BASE: q.base <= cfg_wdata;
                        OFS_SIZE: q.size <= cfg_wdata;
                        OFS_PERM: q.perm <= cfg_wdata;
                        default:  q <= q;
                    endcase
                end
            end
            assign windows[r] = q;
        end
    end
endmodule

// File: rtl/tgt_guard_match.sv
module tgt_guard_match
    import tgt_guard_pkg::*;
#(
    parameter int unsigned NR = 4,
    parameter int unsigned AW = 32,
    parameter int unsigned IW = 3,
    parameter int unsigned DW = 2
) (
    input  window_t [NR-1:0] windows,
    input  logic [AW-1:0]    addr,
    input  logic             write,
    input  logic             priv,
    input  logic [IW-1:0]    init,
    input  logic [DW-1:0]    dom,
    output logic             allow
);
    logic [NR-1:0] grant;
    logic [31:0]   addr32;
    kind_e         kind;

    assign addr32 = 32'(addr);
    assign kind   = kind_of(priv, write);

    for (genvar r = 0; r < NR; r++) begin : g_chk
        logic [3:0] kmask;
        logic [7:0] imask;
        logic [7:0] dmask;
        assign kmask = windows[r].perm[PERM_KIND_LO +: 4];
        assign imask = windows[r].perm[PERM_INIT_LO +: 8];
        assign dmask = windows[r].perm[PERM_DOM_LO +: 8];
        assign grant[r] = windows[r].perm[PERM_EN]
                        && in_window(addr32, windows[r].base, windows[r].size)
                        && kmask[kind]
                        && imask[3'(init)]
                        && dmask[3'(dom)];
    end

    assign allow = |grant;
endmodule

// File: rtl/tgt_guard_errlog.sv
module tgt_guard_errlog #(
    parameter int unsigned AW = 32,
    parameter int unsigned IW = 3,
    parameter int unsigned DW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           deny,
    input  logic           clr,
    input  logic [AW-1:0]  addr,
    input  logic           write,
    input  logic           priv,
    input  logic [IW-1:0]  init,
    input  logic [DW-1:0]  dom,
    output logic           full,
    output logic           ovf,
    output logic [31:0]    log_addr,
    output logic [31:0]    log_info
);
    logic [31:0] info_d;

    always_comb begin
        info_d        = '0;
        info_d[7:0]   = 8'(init);
        info_d[15:8]  = 8'(dom);
        info_d[17:16] = {priv, write};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full     <= 1'b0;
            ovf      <= 1'b0;
            log_addr <= '0;
            log_info <= '0;
        end else begin
            if (clr) begin
                full <= 1'b0;
                ovf  <= 1'b0;
            end
            if (deny) begin
                if (full && !clr) begin
                    ovf <= 1'b1;
                end else begin
                    full     <= 1'b1;
                    log_addr <= 32'(addr);
                    log_info <= info_d;
                end
            end
        end
    end
endmodule

// File: rtl/tgt_guard.sv
module tgt_guard
    import tgt_guard_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned NR = 4,
    parameter int unsigned IW = 3,
    parameter int unsigned DW = 2,
    parameter logic [IW-1:0] CFG_INIT = '1,
    parameter logic [DW-1:0] CFG_DOM = '1,
    parameter logic [NR-1:0] HARD_MASK = '0,
    parameter logic [NR*32-1:0] HARD_BASE = '0,
    parameter logic [NR*32-1:0] HARD_SIZE = '0,
    parameter logic [NR*32-1:0] HARD_PERM = '0,
    localparam int unsigned CAW = $clog2(NR * 4 + 4)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic            req_write,
    input  logic            req_priv,
    input  logic [IW-1:0]   req_init,
    input  logic [DW-1:0]   req_dom,
    output logic            tgt_valid,
    output logic [AW-1:0]   tgt_addr,
    output logic            tgt_write,
    output logic            tgt_priv,
    output logic            req_err,
    input  logic            cfg_we,
    input  logic [CAW-1:0]  cfg_addr,
    input  logic [31:0]     cfg_wdata,
    input  logic [IW-1:0]   cfg_init,
    input  logic [DW-1:0]   cfg_dom,
    output logic [31:0]     cfg_rdata,
    output logic            irq
);
    localparam logic [CAW-1:0] CTRL_A = CAW'(NR * 4);
    localparam logic [CAW-1:0] STAT_A = CAW'(NR * 4 + 1);
    localparam logic [CAW-1:0] LOGA_A = CAW'(NR * 4 + 2);
    localparam logic [CAW-1:0] LOGI_A = CAW'(NR * 4 + 3);

    window_t [NR-1:0] windows;
    logic             locked;
    logic             wr_ok;
    logic             allow;
    logic             clr;
    logic             ovf;
    logic [31:0]      log_addr;
    logic [31:0]      log_info;

    tgt_guard_regs #(
        .NR(NR), .IW(IW), .DW(DW), .CAW(CAW),
        .CFG_INIT(CFG_INIT), .CFG_DOM(CFG_DOM),
        .HARD_MASK(HARD_MASK), .HARD_BASE(HARD_BASE),
        .HARD_SIZE(HARD_SIZE), .HARD_PERM(HARD_PERM)
    ) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_init(cfg_init), .cfg_dom(cfg_dom),
        .windows(windows), .locked(locked), .wr_ok(wr_ok)
    );

    tgt_guard_match #(.NR(NR), .AW(AW), .IW(IW), .DW(DW)) u_match (
        .windows(windows), .addr(req_addr), .write(req_write),
        .priv(req_priv), .init(req_init), .dom(req_dom), .allow(allow)
    );

    assign clr = wr_ok && (cfg_addr == STAT_A) && cfg_wdata[0];

    tgt_guard_errlog #(.AW(AW), .IW(IW), .DW(DW)) u_log (
        .clk(clk), .rst(rst), .deny(req_err), .clr(clr),
        .addr(req_addr), .write(req_write), .priv(req_priv),
        .init(req_init), .dom(req_dom), .full(irq), .ovf(ovf),
        .log_addr(log_addr), .log_info(log_info)
    );

    // Zero-latency pass/deny
    assign tgt_valid = req_valid && allow;
    assign req_err   = req_valid && !allow;
    assign tgt_addr  = req_addr;
    assign tgt_write = req_write;
    assign tgt_priv  = req_priv;

    always_comb begin
        cfg_rdata = '0;
        for (int r = 0; r < NR; r++) begin
            if (cfg_addr[CAW-1:2] == (CAW-2)'(r)) begin
                case (cfg_addr[1:0])
                    OFS_BASE: cfg_rdata = windows[r].base;
                    OFS_SIZE: cfg_rdata = windows[r].size;
                    OFS_PERM: cfg_rdata = windows[r].perm;
                    default:  cfg_rdata = '0;
                endcase
            end
        end
        case (cfg_addr)
            CTRL_A:  cfg_rdata = {31'b0, locked};
            STAT_A:  cfg_rdata = {30'b0, ovf, irq};
            LOGA_A:  cfg_rdata = log_addr;
            LOGI_A:  cfg_rdata = log_info;
            default: ;
        endcase
    end
endmodule

// File: rtl/tgt_guard_chk.sv
module tgt_guard_chk #(
    parameter int unsigned NR = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              tgt_valid,
    input logic              req_err,
    input logic              irq,
    input logic              ovf,
    input logic              clr,
    input logic              locked,
    input logic [31:0]       log_addr,
    input logic [NR*96-1:0]  cfg_bits
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (tgt_valid ^ req_err)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!tgt_valid && !req_err)); // R6
    AST_DENY_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        req_err |=> irq); // R11
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq); // R11
    AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (rst)
        (irq && req_err && !clr) |=> ovf); // R12
    AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> $stable(log_addr)); // R12
    AST_LOCK_ONEWAY: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked); // R8
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(cfg_bits)); // R8
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (clr && !req_err) |=> (!irq && !ovf)); // R13
endmodule

bind tgt_guard tgt_guard_chk #(.NR(NR)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .tgt_valid(tgt_valid),
    .req_err(req_err), .irq(irq), .ovf(ovf), .clr(clr), .locked(locked),
    .log_addr(log_addr), .cfg_bits(windows)
);

// File: tb/sim_tgt_guard.sv
`timescale 1ns/1ps
module sim_tgt_guard;
    localparam int unsigned NR = 4;
    localparam int unsigned CAW = 5;
    localparam logic [4:0] CTRL = 5'd16;
    localparam logic [4:0] STAT = 5'd17;
    localparam logic [4:0] LOGA = 5'd18;
    localparam logic [4:0] LOGI = 5'd19;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_priv = 1'b0;
    logic [2:0]  req_init = '0;
    logic [1:0]  req_dom = '0;
    logic        tgt_valid;
    logic [31:0] tgt_addr;
    logic        tgt_write;
    logic        tgt_priv;
    logic        req_err;
    logic        cfg_we = 1'b0;
    logic [CAW-1:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  cfg_init = 3'd7;
    logic [1:0]  cfg_dom = 2'd3;
    logic [31:0] cfg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    tgt_guard #(
        .AW(32), .NR(NR), .IW(3), .DW(2),
        .CFG_INIT(3'd7), .CFG_DOM(2'd3),
        .HARD_MASK(4'b1000),
        .HARD_BASE({32'h0000_8000, 96'h0}),
        .HARD_SIZE({32'h0000_0100, 96'h0}),
        .HARD_PERM({32'h0001_01F1, 96'h0})
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_priv(req_priv), .req_init(req_init),
        .req_dom(req_dom), .tgt_valid(tgt_valid), .tgt_addr(tgt_addr),
        .tgt_write(tgt_write), .tgt_priv(tgt_priv), .req_err(req_err),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_init(cfg_init), .cfg_dom(cfg_dom), .cfg_rdata(cfg_rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one-cycle request, expected outcome pushed to the scoreboard
    task automatic req(input logic [31:0] a, input bit wr, input bit pr,
                       input logic [2:0] ini, input logic [1:0] dm,
                       input bit allow, input string tag);
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = a; req_write = wr; req_priv = pr;
        req_init = ini; req_dom = dm;
        exp_q.push_back(allow);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    // Monitor: compare outcome in the same cycle as the request
    always @(negedge clk) begin
        if (req_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected request", 32'(req_valid), 32'd0);
            end else begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk((tgt_valid == e) && (req_err == !e) && (tgt_addr == req_addr),
                    {t, " R6 outcome"}, {30'b0, tgt_valid, req_err}, {30'b0, e, !e});
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d,
                      input logic [2:0] ini, input logic [1:0] dm);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_init = ini; cfg_dom = dm;
        @(posedge clk); #1;
        cfg_we = 1'b0; cfg_init = 3'd7; cfg_dom = 2'd3;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        cfg_addr = a;
        @(negedge clk);
        chk(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        rd(5'd2, 32'h0, "R1 window0 perm");
        rd(5'd4, 32'h0, "R1 window1 base");
        rd(CTRL, 32'h0, "R1 lock");
        rd(STAT, 32'h0, "R1 status");
        chk(irq == 1'b0, "R1 irq", 32'(irq), 32'd0);
        // R10: hardwired window live from reset
        rd(5'd12, 32'h8000, "R10 fixed base");
        req(32'h8010, 1, 1, 3'd0, 2'd0, 1'b1, "R10 fixed grant");
        // R1 / R11: first denial
        req(32'h100, 0, 0, 3'd1, 2'd1, 1'b0, "R1 deny-all");
        rd(STAT, 32'h1, "R11 irq set");
        rd(LOGA, 32'h100, "R11 log addr");
        rd(LOGI, 32'h0000_0101, "R11 log info");
        // R12: second denial overflows, first record kept
        req(32'h200, 1, 1, 3'd2, 2'd0, 1'b0, "R12 second deny");
        rd(STAT, 32'h3, "R12 overflow");
        rd(LOGA, 32'h100, "R12 first addr kept");
        rd(LOGI, 32'h0000_0101, "R12 first info kept");
        // R13: clear
        wr(STAT, 32'h1, 3'd7, 2'd3);
        rd(STAT, 32'h0, "R13 cleared");
        chk(irq == 1'b0, "R13 irq low", 32'(irq), 32'd0);
        // R9: unauthorised writers
        wr(5'd0, 32'h1234, 3'd1, 2'd3);
        wr(5'd0, 32'h1234, 3'd7, 2'd0);
        rd(5'd0, 32'h0, "R9 write ignored");
        // R10: fixed window ignores writes
        wr(5'd12, 32'h5000, 3'd7, 2'd3);
        rd(5'd12, 32'h8000, "R10 base unchanged");
        rd(5'd14, 32'h0001_01F1, "R10 perm fixed");
        req(32'h8010, 1, 1, 3'd1, 2'd0, 1'b0, "R10 fixed deny");
        // program windows 0 and 1
        wr(5'd0, 32'h1000, 3'd7, 2'd3);
        wr(5'd1, 32'h100, 3'd7, 2'd3);
        wr(5'd2, 32'h0001_06F1, 3'd7, 2'd3);
        wr(5'd4, 32'h1080, 3'd7, 2'd3);
        wr(5'd5, 32'h100, 3'd7, 2'd3);
        wr(5'd6, 32'h0002_0811, 3'd7, 2'd3);
        rd(5'd2, 32'h0001_06F1, "R8 perm written before lock");
        // R2 bounds
        req(32'h1000, 0, 0, 3'd1, 2'd0, 1'b1, "R2 base");
        req(32'h10FF, 1, 1, 3'd2, 2'd0, 1'b1, "R2 last");
        req(32'h1100, 0, 0, 3'd1, 2'd0, 1'b0, "R2 end");
        req(32'h0FFF, 0, 0, 3'd1, 2'd0, 1'b0, "R2 below");
        // R3 initiator
        req(32'h1010, 0, 0, 3'd0, 2'd0, 1'b0, "R3 init0");
        req(32'h1010, 0, 0, 3'd3, 2'd0, 1'b0, "R3 init3");
        // R4 domain
        req(32'h1010, 0, 0, 3'd1, 2'd2, 1'b0, "R4 dom2");
        req(32'h1010, 0, 1, 3'd2, 2'd0, 1'b1, "R4 dom0");
        // R5 access kind on window 1 (user read only)
        req(32'h1150, 0, 0, 3'd3, 2'd1, 1'b1, "R5 user read");
        req(32'h1150, 1, 0, 3'd3, 2'd1, 1'b0, "R5 user write");
        req(32'h1150, 0, 1, 3'd3, 2'd1, 1'b0, "R5 sup read");
        req(32'h1150, 1, 1, 3'd3, 2'd1, 1'b0, "R5 sup write");
        // R7 overlap 0x1080..0x10FF
        req(32'h10A0, 0, 0, 3'd3, 2'd1, 1'b1, "R7 via window1");
        req(32'h10A0, 1, 1, 3'd1, 2'd0, 1'b1, "R7 via window0");
        // R8 lock
        wr(STAT, 32'h1, 3'd7, 2'd3);
        wr(CTRL, 32'h1, 3'd7, 2'd3);
        rd(CTRL, 32'h1, "R8 lock set");
        wr(CTRL, 32'h0, 3'd7, 2'd3);
        rd(CTRL, 32'h1, "R8 lock sticky");
        wr(5'd0, 32'h0, 3'd7, 2'd3);
        wr(5'd2, 32'h0, 3'd7, 2'd3);
        rd(5'd0, 32'h1000, "R8 base frozen");
        rd(5'd2, 32'h0001_06F1, "R8 perm frozen");
        req(32'h1000, 0, 0, 3'd1, 2'd0, 1'b1, "R8 still grants");
        // R11 / R13 after lock
        rd(STAT, 32'h0, "R13 empty before");
        req(32'h2000, 1, 0, 3'd0, 2'd2, 1'b0, "R11 deny after lock");
        rd(LOGA, 32'h2000, "R11 addr after lock");
        rd(LOGI, 32'h0001_0200, "R11 info after lock");
        wr(STAT, 32'h1, 3'd7, 2'd3);
        rd(STAT, 32'h0, "R13 clear after lock");

        repeat (2) @(posedge clk);
        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule